// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Timer

This block times the chopping cycle of a full-bridge motor driver that regulates winding current with a fixed off-time. It runs on the driver's oscillator clock. When the bridge is on and the external sense comparator reports that the current has reached its limit, the block turns the source side off for a programmed number of oscillator cycles. During that off period the current either recirculates in fast decay, in slow decay, or in a mix that starts fast and ends slow.

After the off period the source side turns back on. A programmable blanking window follows, during which the comparator is ignored. This keeps the turn-on current spike from cutting the next on period short. Blanking also restarts whenever the bridge is enabled or the direction input changes.

When external PWM is selected, the comparator is not used. The bridge stays on while it is enabled, and only the blanking behaviour on enable and direction events remains.

Top module: `ot_pwm_timer`

## Requirements
- R1: While the synchronous active-low reset is held, source_en_o, fast_decay_o, slow_decay_o and blank_o are all low.
- R2: A low enable_i forces all four outputs low at the next clock edge and clears the timer. A later enable therefore starts from a fresh, full-length blanking window.
- R3: The first edge with enable_i high after it was low starts blanking. source_en_o and blank_o are both high for the number of cycles set by blank_code_i: 0 gives 4, 1 gives 6, 2 gives 12, 3 gives 24.
- R4: When trip_i is high in the on state (source on, not blanking, ext_pwm_i low), the next cycle starts an off period with source_en_o low. The off period lasts 8·n+7 cycles, where n is the 5-bit off_code_i.
- R5: With mixed_i = 1, the first 8·m+7 cycles of the off period show fast_decay_o, where m is the 4-bit fast_code_i. The remaining cycles show slow_decay_o.
- R6: With mixed_i = 1, if 8·m+7 is at least the off-period length, fast_decay_o covers the whole off period and slow_decay_o never rises.
- R7: With mixed_i = 0, the whole off period shows slow_decay_o.
- R8: The cycle after the last off cycle starts a blanking window of the length set in R3. The on state follows that window.
- R9: trip_i is ignored while blanking and during the off period. A trip held high through both changes neither length.
- R10: A change on dir_i while enabled restarts blanking in the following cycle, from any state. The restarted window has its full length.
- R11: With ext_pwm_i = 1, trip_i has no effect. After blanking, source_en_o stays high and no decay flag rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all counts are in its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Effective bridge enable; low chops the bridge |
| dir_i | input | 1 | Bridge direction; any change restarts blanking |
| ext_pwm_i | input | 1 | 1 = external PWM, comparator ignored; 0 = internal current regulation |
| mixed_i | input | 1 | 1 = mixed decay, 0 = slow decay |
| trip_i | input | 1 | Current-limit comparator output |
| blank_code_i | input | 2 | Blanking length code |
| off_code_i | input | OFF_W | Off-time code n, length 8·n+7 |
| fast_code_i | input | FD_W | Fast-decay code m, length 8·m+7 |
| source_en_o | output | 1 | Source-side drivers enabled |
| fast_decay_o | output | 1 | Off period in its fast-decay phase |
| slow_decay_o | output | 1 | Off period in its slow-decay phase |
| blank_o | output | 1 | Comparator blanking active |

## Verification
All of the block's state is one phase register and one shared counter. A counter that stops one cycle early or late shows up as a wrong run length: fast_decay_o, slow_decay_o or blank_o stays high for one cycle too few or too many. That error is visible by the end of the first off period or blanking window after the fault. A phase register that takes a trip while blanking or while off shows up within one cycle, because a decay flag rises during blanking or an off period restarts. A missed direction or enable event shows up on the very next edge, because blank_o fails to rise.

// File: rtl/ot_pwm_pkg.sv
package ot_pwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BLANK,
    ST_ON,
    ST_OFF
  } ot_state_e;

  localparam int LEN_W = 16;
  typedef logic [LEN_W-1:0] len_t;

  // Length of a timed phase for code n: 8*(n+1)-1 cycles.
  function automatic len_t period_len(input len_t code);
    return (code << 3) + len_t'(7);
  endfunction

  // Blanking length selected by a two-bit code.
  function automatic len_t blank_len(input logic [1:0] code);
    case (code)
      2'd0:    return len_t'(4);
      2'd1:    return len_t'(6);
      2'd2:    return len_t'(12);
      default: return len_t'(24);
    endcase
  endfunction

endpackage

// File: rtl/ot_edge_det.sv
module ot_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic chg_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign chg_o = sig_i ^ sig_q;
endmodule

// File: rtl/ot_seq.sv
module ot_seq
  import ot_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             trip_ok_i,
  input  logic [CNT_W-1:0] off_len_i,
  input  logic [CNT_W-1:0] blk_len_i,
  output ot_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             off_done_o,
  output logic             blank_done_o
);
  ot_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  assign off_done_o   = (state_q == ST_OFF)   && (cnt_q == off_len_i - CNT_W'(1));
  assign blank_done_o = (state_q == ST_BLANK) && (cnt_q == blk_len_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (state_q == ST_IDLE || restart_i) begin
      state_q <= ST_BLANK;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_BLANK: begin
          if (blank_done_o) begin
            state_q <= ST_ON;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_ON: begin
          if (trip_ok_i) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
          end
        end
        ST_OFF: begin
          if (off_done_o) begin
            state_q <= ST_BLANK;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ot_pwm_timer.sv
module ot_pwm_timer
  import ot_pwm_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int FD_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             dir_i,
  input  logic             ext_pwm_i,
  input  logic             mixed_i,
  input  logic             trip_i,
  input  logic [1:0]       blank_code_i,
  input  logic [OFF_W-1:0] off_code_i,
  input  logic [FD_W-1:0]  fast_code_i,
  output logic             source_en_o,
  output logic             fast_decay_o,
  output logic             slow_decay_o,
  output logic             blank_o
);
  localparam int CNT_W = (OFF_W + 3 > 5) ? OFF_W + 3 : 5;

  // Named internal events, observed by the bound checker.
  logic             dir_chg;
  logic             trip_take;
  logic             off_done;
  logic             blank_done;
  logic             fast_phase;
  ot_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] off_len;
  logic [CNT_W-1:0] blk_len;
  len_t             fd_len;

  assign off_len = CNT_W'(period_len(len_t'(off_code_i)));
  assign blk_len = CNT_W'(blank_len(blank_code_i));
  assign fd_len  = period_len(len_t'(fast_code_i));

  ot_edge_det u_dir_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (dir_i),
    .chg_o (dir_chg)
  );

  ot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (enable_i),
    .restart_i    (dir_chg),
    .trip_ok_i    (trip_i && !ext_pwm_i),
    .off_len_i    (off_len),
    .blk_len_i    (blk_len),
    .state_o      (state),
    .cnt_o        (cnt),
    .off_done_o   (off_done),
    .blank_done_o (blank_done)
  );

  assign trip_take  = enable_i && !dir_chg && (state == ST_ON) && trip_i && !ext_pwm_i;
  assign fast_phase = mixed_i && (len_t'(cnt) < fd_len);

  assign source_en_o  = (state == ST_BLANK) || (state == ST_ON);
  assign blank_o      = (state == ST_BLANK);
  assign fast_decay_o = (state == ST_OFF) && fast_phase;
  assign slow_decay_o = (state == ST_OFF) && !fast_phase;
endmodule

// File: rtl/ot_pwm_timer_chk.sv
module ot_pwm_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable_i,
  input logic ext_pwm_i,
  input logic mixed_i,
  input logic source_en_o,
  input logic fast_decay_o,
  input logic slow_decay_o,
  input logic blank_o,
  input logic dir_chg,
  input logic trip_take,
  input logic off_done,
  input logic blank_done
);
  p_disable_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !source_en_o && !blank_o && !fast_decay_o && !slow_decay_o);

  p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({source_en_o, fast_decay_o, slow_decay_o}));

  p_trip_starts_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_take |=> !source_en_o && (fast_decay_o || slow_decay_o));

  p_no_fast_after_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slow_decay_o && mixed_i |=> !fast_decay_o);

  p_off_exits_to_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_done && enable_i && !dir_chg |=> blank_o);

  p_blank_ends_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_done && enable_i && !dir_chg |=> source_en_o && !blank_o);

  p_blank_masks_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o && enable_i |=> !fast_decay_o && !slow_decay_o);

  p_dir_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_chg && enable_i |=> blank_o);

  p_ext_holds_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pwm_i && source_en_o && !blank_o && enable_i && !dir_chg |=> source_en_o && !blank_o);
endmodule

bind ot_pwm_timer ot_pwm_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_i     (enable_i),
  .ext_pwm_i    (ext_pwm_i),
  .mixed_i      (mixed_i),
  .source_en_o  (source_en_o),
  .fast_decay_o (fast_decay_o),
  .slow_decay_o (slow_decay_o),
  .blank_o      (blank_o),
  .dir_chg      (dir_chg),
  .trip_take    (trip_take),
  .off_done     (off_done),
  .blank_done   (blank_done)
);

// File: tb/ot_pwm_timer_tb.sv
module ot_pwm_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable_i, dir_i, ext_pwm_i, mixed_i, trip_i;
  logic [1:0] blank_code_i;
  logic [4:0] off_code_i;
  logic [3:0] fast_code_i;
  logic       source_en_o, fast_decay_o, slow_decay_o, blank_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ot_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .dir_i(dir_i),
    .ext_pwm_i(ext_pwm_i), .mixed_i(mixed_i), .trip_i(trip_i),
    .blank_code_i(blank_code_i), .off_code_i(off_code_i), .fast_code_i(fast_code_i),
    .source_en_o(source_en_o), .fast_decay_o(fast_decay_o),
    .slow_decay_o(slow_decay_o), .blank_o(blank_o)
  );

  typedef struct packed {
    logic [4:0] toff;
    logic [3:0] tfd;
    logic [1:0] blk;
    logic       mix;
    logic [7:0] e_fast;
    logic [7:0] e_slow;
    logic [4:0] e_blank;
  } vec_t;

  // Expected counts: off = 8n+7, fast = min(8m+7, off) in mixed mode, blank per code.
  localparam vec_t VECS [0:5] = '{
    '{5'd0,  4'd0,  2'd0, 1'b1, 8'd7,   8'd0,   5'd4},
    '{5'd3,  4'd1,  2'd1, 1'b1, 8'd15,  8'd16,  5'd6},
    '{5'd31, 4'd15, 2'd2, 1'b1, 8'd127, 8'd128, 5'd12},
    '{5'd2,  4'd5,  2'd3, 1'b1, 8'd23,  8'd0,   5'd24},
    '{5'd4,  4'd2,  2'd0, 1'b0, 8'd0,   8'd39,  5'd4},
    '{5'd1,  4'd1,  2'd3, 1'b1, 8'd15,  8'd0,   5'd24}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_blank(output int n);
    n = 0;
    while (blank_o && n < 1000) begin n++; tick(); end
  endtask

  task automatic count_off(output int nf, output int ns);
    nf = 0; ns = 0;
    while ((fast_decay_o || slow_decay_o) && (nf + ns) < 1000) begin
      if (fast_decay_o) nf++;
      if (slow_decay_o) ns++;
      tick();
    end
  endtask

  task automatic restart_with(input logic [4:0] t, input logic [3:0] f,
                              input logic [1:0] b, input logic m);
    enable_i = 1'b0; tick(); tick();
    off_code_i = t; fast_code_i = f; blank_code_i = b; mixed_i = m;
    enable_i = 1'b1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb, nf, ns, bad;
    rst_n = 1'b0; enable_i = 1'b1; dir_i = 1'b0; ext_pwm_i = 1'b0; mixed_i = 1'b1;
    trip_i = 1'b0; blank_code_i = 2'd0; off_code_i = 5'd0; fast_code_i = 4'd0;
    tick(); tick(); tick();
    // R1: reset holds every output low
    check("R1", "outputs in reset",
          int'({source_en_o, fast_decay_o, slow_decay_o, blank_o}), 0);
    rst_n = 1'b1;
    enable_i = 1'b0; tick();

    // Table of configurations: R3, R4, R5, R6, R7, R8
    for (int i = 0; i < 6; i++) begin
      restart_with(VECS[i].toff, VECS[i].tfd, VECS[i].blk, VECS[i].mix);
      check("R3", "enable blank cycles", int'(source_en_o), 1);
      count_blank(nb);
      check("R3", "enable blank length", nb, int'(VECS[i].e_blank));
      check("R8", "on after blank", int'(source_en_o && !blank_o), 1);
      trip_i = 1'b1; tick(); trip_i = 1'b0;
      check("R4", "source off after trip", int'(source_en_o), 0);
      count_off(nf, ns);
      check("R4", "off period length", nf + ns, int'(VECS[i].e_fast) + int'(VECS[i].e_slow));
      check(VECS[i].mix ? "R5/R6" : "R7", "fast cycles", nf, int'(VECS[i].e_fast));
      check(VECS[i].mix ? "R5/R6" : "R7", "slow cycles", ns, int'(VECS[i].e_slow));
      count_blank(nb);
      check("R8", "blank after off", nb, int'(VECS[i].e_blank));
    end

    // R9: trip held high through blanking and the off period
    trip_i = 1'b1;
    restart_with(5'd0, 4'd0, 2'd0, 1'b1);
    count_blank(nb);
    check("R9", "blank with trip held", nb, 4);
    check("R9", "single on cycle", int'(source_en_o && !blank_o), 1);
    tick();
    count_off(nf, ns);
    check("R9", "off length with trip held", nf + ns, 7);
    count_blank(nb);
    check("R9", "second blank with trip held", nb, 4);
    trip_i = 1'b0;

    // R10: direction change in the middle of an off period
    restart_with(5'd3, 4'd0, 2'd1, 1'b0);
    count_blank(nb);
    trip_i = 1'b1; tick(); trip_i = 1'b0;
    tick(); tick(); tick();
    dir_i = ~dir_i; tick();
    check("R10", "blank after dir change", int'(blank_o && !slow_decay_o), 1);
    count_blank(nb);
    check("R10", "restarted blank length", nb, 6);

    // R2: disable in the middle of an off period, then a fresh blank
    trip_i = 1'b1; tick(); trip_i = 1'b0;
    tick(); tick();
    enable_i = 1'b0; tick();
    check("R2", "outputs after disable",
          int'({source_en_o, fast_decay_o, slow_decay_o, blank_o}), 0);
    enable_i = 1'b1; tick();
    count_blank(nb);
    check("R2", "full blank after re-enable", nb, 6);

    // R11: external PWM ignores trip
    ext_pwm_i = 1'b1;
    restart_with(5'd0, 4'd0, 2'd0, 1'b1);
    count_blank(nb);
    trip_i = 1'b1; bad = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (!source_en_o || fast_decay_o || slow_decay_o || blank_o) bad++;
    end
    check("R11", "cycles leaving on state", bad, 0);
    trip_i = 1'b0; ext_pwm_i = 1'b0; tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule